// File: doc/BRIEF.md
# Fixed-Point Condition Flag Register with Bypass

This block keeps the five frequently used fixed-point exception flags of a 64-bit core: carry, 32-bit carry, overflow, 32-bit overflow and summary overflow. Three writeback sources can update the register: the ALU, the multiplier and the divider. Each source has its own write enable for the flags. When more than one source writes in the same cycle, the block flags an error. The decode stage reads the register through a write-through port, so a write landing in the same cycle is already visible to it.

The execute stage forwards the flags it produced itself. When the operation in the previous cycle updated the flags, the execute stage uses that latched value in place of the copy read in decode. This removes the need to track flag hazards. The latched execute output always carries a valid flag set with each result, including results that did not write the flags, so that summary overflow can reach condition field 0.

The block also does three conversions:
- It packs the flags into a 64-bit special-register image for move-from operations.
- It unpacks that image for move-to operations.
- It builds the condition field 0 nibble and its field mask for record-form results.

Top module: `flag_bypass_unit`

## Requirements
- R1: After reset all five flags are zero. `rd_flags_o`, `ex_flags_o`, `ex_res_flags_o` and `ex_res_we_o` read zero until the first write. Flag vectors are encoded as bit4 SO, bit3 OV, bit2 CA, bit1 OV32, bit0 CA32.
- R2: The stored flags change on a rising clock edge only when at least one of `alu_we_i`, `mul_we_i` or `div_we_i` is high. Otherwise the stored value is held.
- R3: `rd_flags_o` is write-through. In a cycle with any write enable high it shows the value being written; otherwise it shows the stored value.
- R4: `wb_conflict_o` is high exactly when two or more writeback enables are high in the same cycle. In that case the ALU wins over the multiplier, and the multiplier wins over the divider.
- R5: `ex_flags_o` equals the flags latched by the execute stage when the previous valid execute operation wrote the flags (the latched `ex_res_we_o` is high). Otherwise it equals `ex_dec_flags_i`.
- R6: `ex_spr_rdata_o` packs `ex_flags_o` at bit positions SO 31, OV 30, CA 29, OV32 19 and CA32 18. Every other bit is zero.
- R7: A valid execute operation with `ex_mtspr_i` high takes the flags from the same bit positions of `ex_spr_wdata_i`. It sets `ex_res_we_o` in the next cycle and has priority over `ex_upd_we_i`.
- R8: For a valid record-form result, `cr_data_o[31:28]` is {LT, GT, EQ, SO}:
  - LT is bit 63 of `rec_data_i`.
  - GT is high when the value is neither negative nor zero.
  - EQ is high when the value is zero.
  - SO is bit4 of `rec_flags_i`.
  
  All other bits of `cr_data_o` are zero.
- R9: `cr_we_o` is high and `cr_mask_o` is 8'h80 (field 0 only) exactly when `rec_valid_i` and `rec_rc_i` are both high. Otherwise `cr_we_o`, `cr_mask_o` and `cr_data_o` are all zero.
- R10: On a valid execute operation without a flag write, `ex_res_flags_o` in the next cycle carries the `ex_flags_o` value that was in use, and `ex_res_we_o` is low. On an idle cycle `ex_res_we_o` drops to zero and `ex_res_flags_o` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alu_we_i | input | 1 | ALU writeback flag write enable |
| alu_flags_i | input | 5 | ALU writeback flag value |
| mul_we_i | input | 1 | Multiplier writeback flag write enable |
| mul_flags_i | input | 5 | Multiplier writeback flag value |
| div_we_i | input | 1 | Divider writeback flag write enable |
| div_flags_i | input | 5 | Divider writeback flag value |
| rd_flags_o | output | 5 | Decode read of the flags (write-through) |
| wb_conflict_o | output | 1 | More than one writeback enable high this cycle |
| ex_valid_i | input | 1 | Execute stage holds a valid operation |
| ex_dec_flags_i | input | 5 | Flags read in decode for this operation |
| ex_upd_we_i | input | 1 | Execute operation updates the flags |
| ex_upd_flags_i | input | 5 | New flag value from the execute operation |
| ex_mtspr_i | input | 1 | Execute operation is a move-to of the flag register |
| ex_spr_wdata_i | input | 64 | Move-to source image |
| ex_flags_o | output | 5 | Flags in effect for the execute operation (after forwarding) |
| ex_spr_rdata_o | output | 64 | Move-from image of `ex_flags_o` |
| ex_res_we_o | output | 1 | Latched: execute result writes the flags |
| ex_res_flags_o | output | 5 | Latched flag value carried with the execute result |
| rec_valid_i | input | 1 | Result for the condition field update is valid |
| rec_rc_i | input | 1 | Record bit of that result |
| rec_data_i | input | 64 | Result value |
| rec_flags_i | input | 5 | Flags carried with that result |
| cr_we_o | output | 1 | Condition register write enable |
| cr_mask_o | output | 8 | Condition field mask (bit 7 = field 0) |
| cr_data_o | output | 32 | Condition register write data, nibble at 31:28 |

## Verification
Several of the block's functions can meet in one cycle, and the bench makes them do so on purpose:
- **Writeback and execute bypass together.** A writeback commit can arrive in the same cycle as an execute-stage self-forward. The decode read must then show the incoming writeback value, while the execute stage must still use its own latched flags.
- **Move-to and ordinary update together.** A move-to and an ordinary flag update can be requested together. The unpacked image must win.

Directed sequences set up each collision, including three-way writeback conflicts. Random traffic at high enable density covers the rest. On every clock, all outputs are compared with a behavioural model that keeps only the stored flags and the latched execute result.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W = 5;
  localparam int XLEN   = 64;
  localparam int N_SRC  = 3;
  // special-register image bit positions
  localparam int POS_SO   = 31;
  localparam int POS_OV   = 30;
  localparam int POS_CA   = 29;
  localparam int POS_OV32 = 19;
  localparam int POS_CA32 = 18;
  localparam int CR_FIELDS = 8;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
    logic ov32;
    logic ca32;
  } flags_t;
endpackage

// File: rtl/flag_store.sv
module flag_store
  import flag_pkg::*;
#(
  parameter int NSRC = N_SRC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSRC-1:0]      we_i,
  input  flags_t [NSRC-1:0]    wdata_i,
  output flags_t               rd_o,
  output logic                 conflict_o
);
  localparam int CNT_W = $clog2(NSRC + 1);

  flags_t          q_r;
  flags_t          sel;
  logic [CNT_W-1:0] n_we;

  // lowest index wins
  always_comb begin
    sel  = wdata_i[0];
    n_we = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (we_i[i]) sel = wdata_i[i];
      n_we = n_we + CNT_W'(we_i[i]);
    end
  end

  assign conflict_o = (n_we > CNT_W'(1));
  assign rd_o       = (|we_i) ? sel : q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_r <= '0;
    else if (|we_i)  q_r <= sel;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|we_i) |=> q_r == $past(q_r));
  assert_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_i) |=> q_r == $past(rd_o));
  assert_first_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[0] |=> q_r == $past(wdata_i[0]));
endmodule

// File: rtl/flag_spr.sv
module flag_spr
  import flag_pkg::*;
#(
  parameter int W = XLEN
) (
  input  flags_t       flags_i,
  output logic [W-1:0] image_o,
  input  logic [W-1:0] image_i,
  output flags_t       flags_o
);
  always_comb begin
    image_o           = '0;
    image_o[POS_SO]   = flags_i.so;
    image_o[POS_OV]   = flags_i.ov;
    image_o[POS_CA]   = flags_i.ca;
    image_o[POS_OV32] = flags_i.ov32;
    image_o[POS_CA32] = flags_i.ca32;
    flags_o.so   = image_i[POS_SO];
    flags_o.ov   = image_i[POS_OV];
    flags_o.ca   = image_i[POS_CA];
    flags_o.ov32 = image_i[POS_OV32];
    flags_o.ca32 = image_i[POS_CA32];
  end
endmodule

// File: rtl/flag_fwd.sv
module flag_fwd
  import flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  flags_t dec_flags_i,
  input  logic   upd_we_i,
  input  flags_t upd_flags_i,
  input  logic   mt_we_i,
  input  flags_t mt_flags_i,
  output flags_t eff_o,
  output logic   res_we_o,
  output flags_t res_flags_o
);
  flags_t nxt;
  logic   nxt_we;

  assign eff_o  = res_we_o ? res_flags_o : dec_flags_i;
  assign nxt_we = mt_we_i | upd_we_i;

  always_comb begin
    if (mt_we_i)       nxt = mt_flags_i;
    else if (upd_we_i) nxt = upd_flags_i;
    else               nxt = eff_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_we_o    <= 1'b0;
      res_flags_o <= '0;
    end else begin
      res_we_o <= valid_i & nxt_we;
      if (valid_i) res_flags_o <= nxt;
    end
  end

  assert_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nxt_we) |=> eff_o == $past(nxt));
  assert_carry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !nxt_we) |=> res_flags_o == $past(eff_o));
endmodule

// File: rtl/cr0_gen.sv
module cr0_gen
  import flag_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic                 valid_i,
  input  logic                 rc_i,
  input  logic [W-1:0]         data_i,
  input  flags_t               flags_i,
  output logic                 we_o,
  output logic [CR_FIELDS-1:0] mask_o,
  output logic [31:0]          data_o
);
  logic lt, eq, gt;

  assign lt   = data_i[W-1];
  assign eq   = ~|data_i;
  assign gt   = ~lt & ~eq;
  assign we_o = valid_i & rc_i;

  always_comb begin
    mask_o = '0;
    data_o = '0;
    if (we_o) begin
      mask_o[CR_FIELDS-1] = 1'b1;
      data_o[31:28]       = {lt, gt, eq, flags_i.so};
    end
  end

  always_comb begin
    if (we_o) assert_cr_class_R8: assert ($countones(data_o[31:29]) == 1);
    assert_mask_R9: assert ($onehot0(mask_o));
  end
endmodule

// File: rtl/flag_bypass_unit.sv
module flag_bypass_unit
  import flag_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        alu_we_i,
  input  logic [4:0]  alu_flags_i,
  input  logic        mul_we_i,
  input  logic [4:0]  mul_flags_i,
  input  logic        div_we_i,
  input  logic [4:0]  div_flags_i,
  output logic [4:0]  rd_flags_o,
  output logic        wb_conflict_o,
  input  logic        ex_valid_i,
  input  logic [4:0]  ex_dec_flags_i,
  input  logic        ex_upd_we_i,
  input  logic [4:0]  ex_upd_flags_i,
  input  logic        ex_mtspr_i,
  input  logic [63:0] ex_spr_wdata_i,
  output logic [4:0]  ex_flags_o,
  output logic [63:0] ex_spr_rdata_o,
  output logic        ex_res_we_o,
  output logic [4:0]  ex_res_flags_o,
  input  logic        rec_valid_i,
  input  logic        rec_rc_i,
  input  logic [63:0] rec_data_i,
  input  logic [4:0]  rec_flags_i,
  output logic        cr_we_o,
  output logic [7:0]  cr_mask_o,
  output logic [31:0] cr_data_o
);
  flags_t [N_SRC-1:0] wb_data;
  flags_t             rd_f, eff_f, mt_f, res_f;

  // index order sets priority: ALU, multiplier, divider
  assign wb_data = {flags_t'(div_flags_i), flags_t'(mul_flags_i), flags_t'(alu_flags_i)};

  flag_store #(.NSRC(N_SRC)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       ({div_we_i, mul_we_i, alu_we_i}),
    .wdata_i    (wb_data),
    .rd_o       (rd_f),
    .conflict_o (wb_conflict_o)
  );

  flag_spr #(.W(XLEN)) u_spr (
    .flags_i (eff_f),
    .image_o (ex_spr_rdata_o),
    .image_i (ex_spr_wdata_i),
    .flags_o (mt_f)
  );

  flag_fwd u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (ex_valid_i),
    .dec_flags_i (flags_t'(ex_dec_flags_i)),
    .upd_we_i    (ex_upd_we_i),
    .upd_flags_i (flags_t'(ex_upd_flags_i)),
    .mt_we_i     (ex_mtspr_i),
    .mt_flags_i  (mt_f),
    .eff_o       (eff_f),
    .res_we_o    (ex_res_we_o),
    .res_flags_o (res_f)
  );

  cr0_gen #(.W(XLEN)) u_cr0 (
    .valid_i (rec_valid_i),
    .rc_i    (rec_rc_i),
    .data_i  (rec_data_i),
    .flags_i (flags_t'(rec_flags_i)),
    .we_o    (cr_we_o),
    .mask_o  (cr_mask_o),
    .data_o  (cr_data_o)
  );

  assign rd_flags_o     = rd_f;
  assign ex_flags_o     = eff_f;
  assign ex_res_flags_o = res_f;

  assert_mtspr_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && ex_mtspr_i) |=> ex_res_we_o);
  assert_mtspr_val_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && ex_mtspr_i) |=> ex_spr_rdata_o[31:29] == $past({ex_spr_wdata_i[31:29]}));
endmodule

// File: tb/flag_bypass_unit_test.sv
module flag_bypass_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_we = 0, mul_we = 0, div_we = 0;
  logic [4:0]  alu_f = 0, mul_f = 0, div_f = 0;
  logic [4:0]  rd_f;
  logic        conflict;
  logic        ex_valid = 0, ex_upd_we = 0, ex_mt = 0;
  logic [4:0]  ex_dec = 0, ex_upd = 0;
  logic [63:0] ex_wimg = 0;
  logic [4:0]  ex_f, res_f;
  logic [63:0] ex_rimg;
  logic        res_we;
  logic        rec_valid = 0, rec_rc = 0;
  logic [63:0] rec_data = 0;
  logic [4:0]  rec_f = 0;
  logic        cr_we;
  logic [7:0]  cr_mask;
  logic [31:0] cr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [4:0] m_st = 0, m_res = 0;
  logic       m_res_we = 0;

  always #2.5 clk = ~clk;

  flag_bypass_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alu_we_i(alu_we), .alu_flags_i(alu_f),
    .mul_we_i(mul_we), .mul_flags_i(mul_f),
    .div_we_i(div_we), .div_flags_i(div_f),
    .rd_flags_o(rd_f), .wb_conflict_o(conflict),
    .ex_valid_i(ex_valid), .ex_dec_flags_i(ex_dec),
    .ex_upd_we_i(ex_upd_we), .ex_upd_flags_i(ex_upd),
    .ex_mtspr_i(ex_mt), .ex_spr_wdata_i(ex_wimg),
    .ex_flags_o(ex_f), .ex_spr_rdata_o(ex_rimg),
    .ex_res_we_o(res_we), .ex_res_flags_o(res_f),
    .rec_valid_i(rec_valid), .rec_rc_i(rec_rc),
    .rec_data_i(rec_data), .rec_flags_i(rec_f),
    .cr_we_o(cr_we), .cr_mask_o(cr_mask), .cr_data_o(cr_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // flags bit order: 4 SO, 3 OV, 2 CA, 1 OV32, 0 CA32
  function automatic logic [63:0] pack(input logic [4:0] f);
    logic [63:0] r = '0;
    r[31] = f[4]; r[30] = f[3]; r[29] = f[2]; r[19] = f[1]; r[18] = f[0];
    return r;
  endfunction

  function automatic logic [4:0] unpack(input logic [63:0] v);
    return {v[31], v[30], v[29], v[19], v[18]};
  endfunction

  // inputs already applied; compare then advance model across next posedge
  task automatic step();
    logic [4:0]  e_rd, e_eff, nxt;
    logic [31:0] e_crd;
    int          nwe;
    #1;
    nwe = int'(alu_we) + int'(mul_we) + int'(div_we);
    e_rd = alu_we ? alu_f : mul_we ? mul_f : div_we ? div_f : m_st;
    chk("R2/R3 rd_flags", 64'(rd_f), 64'(e_rd));
    chk("R4 conflict", 64'(conflict), 64'(nwe > 1));
    e_eff = m_res_we ? m_res : ex_dec;
    chk("R5 ex_flags", 64'(ex_f), 64'(e_eff));
    chk("R6 spr image", ex_rimg, pack(e_eff));
    chk("R7/R10 res_we", 64'(res_we), 64'(m_res_we));
    chk("R10 res_flags", 64'(res_f), 64'(m_res));
    e_crd = '0;
    if (rec_valid && rec_rc)
      e_crd[31:28] = {rec_data[63], !rec_data[63] && rec_data != 0, rec_data == 0, rec_f[4]};
    chk("R9 cr_we", 64'(cr_we), 64'(rec_valid && rec_rc));
    chk("R9 cr_mask", 64'(cr_mask), (rec_valid && rec_rc) ? 64'h80 : 64'h0);
    chk("R8 cr_data", 64'(cr_data), 64'(e_crd));
    // advance model
    if (nwe > 0) m_st = e_rd;
    nxt = ex_mt ? unpack(ex_wimg) : ex_upd_we ? ex_upd : e_eff;
    if (ex_valid) m_res = nxt;
    m_res_we = ex_valid && (ex_mt || ex_upd_we);
    @(negedge clk);
  endtask

  task automatic idle();
    alu_we = 0; mul_we = 0; div_we = 0;
    ex_valid = 0; ex_upd_we = 0; ex_mt = 0;
    rec_valid = 0; rec_rc = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_flags reset", 64'(rd_f), 64'h0);
    chk("R1 res_we reset", 64'(res_we), 64'h0);
    chk("R1 res_flags reset", 64'(res_f), 64'h0);
    chk("R1 ex_flags reset", 64'(ex_f), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 single ALU write, then hold
    alu_we = 1; alu_f = 5'b10101; step();
    idle(); step(); step();
    // R4 three-way conflict: ALU wins
    alu_we = 1; mul_we = 1; div_we = 1; alu_f = 5'b00011; mul_f = 5'b11000; div_f = 5'b11111; step();
    // R4 mul vs div: mul wins
    idle(); mul_we = 1; div_we = 1; mul_f = 5'b01010; div_f = 5'b10001; step();
    idle(); div_we = 1; div_f = 5'b11100; step();
    idle(); step();

    // R5 self-forward back to back while writeback commits elsewhere
    ex_valid = 1; ex_dec = 5'b00000; ex_upd_we = 1; ex_upd = 5'b10110; step();
    ex_upd_we = 0; ex_dec = 5'b01001; alu_we = 1; alu_f = 5'b00111; step();
    idle(); ex_valid = 1; ex_dec = 5'b01001; step();
    // R7 move-to beats ordinary update
    ex_mt = 1; ex_upd_we = 1; ex_upd = 5'b00001; ex_wimg = 64'hFFFF_FFFF_A004_0000; step();
    idle(); ex_valid = 1; ex_dec = 5'b00000; step();
    // R6 move-from of all-ones image
    idle(); ex_valid = 1; ex_mt = 1; ex_wimg = '1; step();
    idle(); ex_valid = 1; ex_dec = 5'b00000; step();
    idle(); step();

    // R8/R9 record forms
    rec_valid = 1; rec_rc = 1; rec_data = 64'h8000_0000_0000_0000; rec_f = 5'b10000; step();
    rec_data = 64'h0; rec_f = 5'b00000; step();
    rec_data = 64'h1; rec_f = 5'b01111; step();
    rec_rc = 0; rec_data = 64'h0; step();
    rec_valid = 0; rec_rc = 1; step();
    idle(); step();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      alu_we    = ($urandom_range(0, 3) == 0);
      mul_we    = ($urandom_range(0, 3) == 0);
      div_we    = ($urandom_range(0, 3) == 0);
      alu_f     = 5'($urandom);
      mul_f     = 5'($urandom);
      div_f     = 5'($urandom);
      ex_valid  = ($urandom_range(0, 3) != 0);
      ex_dec    = 5'($urandom);
      ex_upd_we = $urandom_range(0, 1) == 1;
      ex_upd    = 5'($urandom);
      ex_mt     = ($urandom_range(0, 5) == 0);
      ex_wimg   = {$urandom, $urandom};
      rec_valid = $urandom_range(0, 1) == 1;
      rec_rc    = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 3))
        0: rec_data = '0;
        1: rec_data = {1'b1, 63'($urandom)};
        default: rec_data = {$urandom, $urandom};
      endcase
      rec_f = 5'($urandom);
      step();
    end

    // asynchronous reset mid-run returns to zero (R1)
    idle();
    rst_n = 1'b0; m_st = 0; m_res = 0; m_res_we = 0;
    #1;
    chk("R1 rd_flags after reset", 64'(rd_f), 64'h0);
    chk("R1 res_flags after reset", 64'(res_f), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule